// File: doc/BRIEF.md
# Channel Status Block Start Controller

This block tracks where a transmitter stands inside a channel status block, which is 192 frames long in stereo operation and 384 frames long in mono operation. It watches the serial port frame-sync clock and keeps a frame index. It also handles a block-start line that can run in either direction. When the line is set as an output, the block counts frame-sync edges and raises the line for one frame each time a new block begins. When the line is set as an input, the block samples an externally driven level on one chosen frame-sync edge. A high sample marks frame 0, and the frame index is forced to 0.

Which frame-sync edge counts depends on a phase setting. In register mode this is a single software bit. In pin mode it comes from the two-bit hardware format code: the code for the I2S-style format selects the inverted phase, and every other code selects the normal phase. The frame-sync clock and the external block-start level both arrive asynchronously. Each passes through a synchronizer of the same depth, and the edges are detected in the system clock domain.

Top module: `blkstart_ctrl`

## Requirements
- R1: After reset, frame_idx is 0, and blk_out, blk_oe and blk_start are all 0.
- R2: blk_oe follows dir_out (1 = line is an output, 0 = line is an input). While blk_oe is 0, blk_out is 0.
- R3: Output mode with phase 0: every falling SYNC edge advances frame_idx. On the 192nd falling edge in stereo, frame_idx returns to 0 and blk_out goes high. blk_out goes low on the next falling edge. Rising edges change nothing.
- R4: Output mode with phase 1: the behaviour of R3 applies to rising SYNC edges, and falling edges change nothing.
- R5: With mono = 1, the block period is 384 counted edges (frame_idx 0 to 383). With mono = 0, it is 192 (frame_idx 0 to 191).
- R6: Input mode with phase 0: blk_in is sampled on rising SYNC edges. A high sample sets frame_idx to 0. Falling edges change nothing.
- R7: Input mode with phase 1: blk_in is sampled on falling SYNC edges instead.
- R8: Input mode: a low sample advances frame_idx by one, and the index wraps from the last frame of the period to 0.
- R9: With pin_mode = 1, the phase is 1 when hw_fmt = 2'b01 and 0 for every other code, and isync_sw has no effect. With pin_mode = 0, the phase is isync_sw.
- R10: blk_start pulses for one clock in the same cycle that frame_idx becomes 0 through a generated block start (output mode) or a detected block start (input mode). A plain wrap in input mode does not pulse it.
- R11: A SYNC change at the pin shows up on frame_idx on the third rising clock edge after it is applied, and not on the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_in | input | 1 | Asynchronous frame-sync clock |
| blk_in | input | 1 | Asynchronous external block-start level |
| dir_out | input | 1 | Line direction: 1 output, 0 input |
| pin_mode | input | 1 | 1 selects phase from hw_fmt, 0 from isync_sw |
| isync_sw | input | 1 | Software frame-sync phase bit |
| hw_fmt | input | 2 | Hardware format code (2'b01 = I2S-style) |
| mono | input | 1 | 1 selects the 384-frame period |
| blk_out | output | 1 | Generated block-start level |
| blk_oe | output | 1 | Output enable for the block-start pad |
| blk_start | output | 1 | One-cycle pulse at the start of a block |
| frame_idx | output | 9 | Current frame index within the block |

## Verification
The assertions assume that SYNC is held at the same level for at least two system clocks on either side of each transition. They also assume that blk_in is steady across the clock on which a sampling edge is seen, and that the mode inputs do not change in the same cycle as a detected edge. The bench holds each SYNC level for at least five clocks. It changes blk_in and the configuration inputs only while SYNC is stable, and it waits at least two clocks before the next transition. Random stimulus is drawn with these limits, so the counting and sampling rules are exercised without ever breaking the synchronizer's assumptions.

// File: rtl/blkstart_ctrl.sv
module blkstart_ctrl #(
  parameter int STEREO_LEN  = 192,
  parameter int MONO_LEN    = 384,
  parameter int SYNC_STAGES = 2,
  localparam int CW = $clog2(MONO_LEN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sync_in,
  input  logic          blk_in,
  input  logic          dir_out,
  input  logic          pin_mode,
  input  logic          isync_sw,
  input  logic [1:0]    hw_fmt,
  input  logic          mono,
  output logic          blk_out,
  output logic          blk_oe,
  output logic          blk_start,
  output logic [CW-1:0] frame_idx
);

  localparam logic [CW-1:0] STEREO_LAST = CW'(STEREO_LEN - 1);
  localparam logic [CW-1:0] MONO_LAST   = CW'(MONO_LEN - 1);
  localparam logic [1:0]    FMT_I2S     = 2'b01;

  logic [SYNC_STAGES-1:0] sync_sh, blk_sh;
  logic                   sync_d, out_q, start_q;
  logic [CW-1:0]          cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_sh <= '0;
      blk_sh  <= '0;
      sync_d  <= 1'b0;
    end else begin
      sync_sh <= {sync_sh[SYNC_STAGES-2:0], sync_in};
      blk_sh  <= {blk_sh[SYNC_STAGES-2:0], blk_in};
      sync_d  <= sync_sh[SYNC_STAGES-1];
    end
  end

  wire          sync_q   = sync_sh[SYNC_STAGES-1];
  wire          blk_q    = blk_sh[SYNC_STAGES-1];
  wire          phase    = pin_mode ? (hw_fmt == FMT_I2S) : isync_sw;
  wire          rise     = sync_q & ~sync_d;
  wire          fall     = ~sync_q & sync_d;
  wire          gen_edge = dir_out & (phase ? rise : fall);
  wire          smp_edge = ~dir_out & (phase ? fall : rise);
  wire [CW-1:0] last     = mono ? MONO_LAST : STEREO_LAST;
  wire          at_last  = cnt >= last;
  wire          det      = smp_edge & blk_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      out_q   <= 1'b0;
      start_q <= 1'b0;
    end else begin
      start_q <= (gen_edge & at_last) | det;
      if (gen_edge)
        cnt <= at_last ? '0 : cnt + 1'b1;
      else if (smp_edge)
        cnt <= (blk_q | at_last) ? '0 : cnt + 1'b1;
      if (!dir_out)
        out_q <= 1'b0;
      else if (gen_edge)
        out_q <= at_last;
    end
  end

  assign blk_oe    = dir_out;
  assign blk_out   = out_q & dir_out;
  assign blk_start = start_q;
  assign frame_idx = cnt;

  assert_oe_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !blk_oe |-> !blk_out);
  assert_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((gen_edge | smp_edge) && at_last) |=> (frame_idx == '0));
  assert_detect_R6: assert property (@(posedge clk) disable iff (!rst_n)
    det |=> (frame_idx == '0 && blk_start));
  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(gen_edge | smp_edge) |=> $stable(frame_idx));
  assert_rise_at_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(blk_out) |-> (frame_idx == '0));
  assert_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_idx <= MONO_LAST);
  assert_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    blk_start |-> (frame_idx == '0));

endmodule

// File: tb/blkstart_ctrl_tb.sv
module blkstart_ctrl_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sync_in = 1'b0, blk_in = 1'b0, dir_out = 1'b0, pin_mode = 1'b0;
  logic isync_sw = 1'b0, mono = 1'b0;
  logic [1:0] hw_fmt = 2'b00;
  logic blk_out, blk_oe, blk_start;
  logic [8:0] frame_idx;

  int tests = 0, fails = 0, seen_starts = 0;
  int m_cnt = 0, m_out = 0, m_starts = 0;

  always #5 clk = ~clk;

  blkstart_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .blk_in(blk_in),
    .dir_out(dir_out), .pin_mode(pin_mode), .isync_sw(isync_sw),
    .hw_fmt(hw_fmt), .mono(mono), .blk_out(blk_out), .blk_oe(blk_oe),
    .blk_start(blk_start), .frame_idx(frame_idx)
  );

  always @(posedge clk) if (rst_n && blk_start) seen_starts++;

  function automatic int phase_of();
    return pin_mode ? int'(hw_fmt == 2'b01) : int'(isync_sw);
  endfunction

  function automatic string tag_of();
    if (pin_mode) return "R9";
    if (dir_out) return mono ? "R5" : (phase_of() ? "R4" : "R3");
    return phase_of() ? "R7" : "R6";
  endfunction

  task automatic check(string req, int act, int exp, string what);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic configure(bit d, bit ph, bit pm, logic [1:0] hf, bit mn);
    @(negedge clk);
    dir_out = d; isync_sw = ph; pin_mode = pm; hw_fmt = hf; mono = mn;
    if (!d) m_out = 0;
    @(negedge clk); @(negedge clk);
    check("R2", blk_oe, d, "blk_oe");
    if (!d) check("R2", blk_out, 0, "blk_out gated");
  endtask

  task automatic toggle(bit blk, bit lat);
    int last, rise, ph, old;
    @(negedge clk);
    blk_in = blk;
    repeat (3) @(negedge clk);
    old = frame_idx;
    sync_in = ~sync_in;
    rise = sync_in;
    ph = phase_of();
    last = mono ? 383 : 191;
    if (dir_out) begin
      if (ph ? rise : !rise) begin
        if (m_cnt >= last) begin m_cnt = 0; m_out = 1; m_starts++; end
        else begin m_cnt++; m_out = 0; end
      end
    end else begin
      m_out = 0;
      if (ph ? !rise : rise) begin
        if (blk) begin m_cnt = 0; m_starts++; end
        else m_cnt = (m_cnt >= last) ? 0 : m_cnt + 1;
      end
    end
    @(posedge clk); @(posedge clk); @(negedge clk);
    if (lat) check("R11", frame_idx, old, "frame_idx before third edge");
    @(posedge clk); @(posedge clk); @(negedge clk);
    if (lat) check("R11", frame_idx, m_cnt, "frame_idx after third edge");
    check(tag_of(), frame_idx, m_cnt, "frame_idx");
    check(tag_of(), blk_out, m_out, "blk_out");
    check("R10", seen_starts, m_starts, "blk_start count");
    @(negedge clk);
    blk_in = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (4) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", frame_idx, 0, "frame_idx");
    check("R1", blk_out, 0, "blk_out");
    check("R1", blk_oe, 0, "blk_oe");
    check("R1", blk_start, 0, "blk_start");

    configure(1, 0, 0, 2'b00, 0);
    for (int i = 0; i < 400; i++) toggle(0, i % 50 == 1);
    configure(1, 1, 0, 2'b00, 0);
    for (int i = 0; i < 400; i++) toggle(0, 0);
    configure(1, 0, 0, 2'b00, 1);
    for (int i = 0; i < 800; i++) toggle(0, 0);
    configure(0, 0, 0, 2'b00, 0);
    for (int i = 0; i < 420; i++) toggle(i == 21 || i == 22, 0);
    configure(0, 1, 0, 2'b00, 1);
    for (int i = 0; i < 40; i++) toggle(i == 7 || i == 10, 0);
    configure(1, 1, 1, 2'b00, 0);
    for (int i = 0; i < 400; i++) toggle(0, 0);
    configure(0, 0, 1, 2'b01, 0);
    for (int i = 0; i < 30; i++) toggle(i == 4 || i == 5, 0);

    for (int i = 0; i < 2500; i++) begin
      if ($urandom_range(49) == 0)
        configure(1'($urandom), 1'($urandom), 1'($urandom),
                  2'($urandom), 1'($urandom));
      toggle($urandom_range(29) == 0, $urandom_range(99) == 0);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule